// File: doc/BRIEF.md
# Serial FIFO Interrupt Control

This block holds the 16-bit control word of a FIFO-based serial port and converts the port's status into four level-sensitive interrupt request lines. The control word carries the transmit and receive enables, the clock-source select and the interrupt enables. The block also keeps the status flags behind those requests. The transmit-empty flag sets when a byte leaves the transmit FIFO and the FIFO is at or below its trigger. It can only be cleared by a read-then-write-zero sequence.

A CPU reaches two words over a simple bus. `bus_sel_i` = 0 selects the control word and `bus_sel_i` = 1 selects the status word. Read data is combinational from the selected word. The shifters, the baud generator and the FIFO storage sit outside the block. They supply fill levels, trigger thresholds and single-cycle event pulses.

Top module: `sfifo_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0, every status bit reads 0, and all four interrupt outputs are 0.
- R2: Control word layout: bit 7 transmit irq enable, bit 6 receive irq enable, bit 5 transmit enable (`tx_en_o`), bit 4 receive enable (`rx_en_o`), bit 3 error irq enable, bits 1:0 clock select (`clk_sel_o`). Bits 15:8 and bit 2 always read 0, and writes to them are dropped.
- R3: Status bit 0 (transmit-empty) sets on the edge where `tx_load_i` is 1 and `tx_level_i <= tx_trig_i`. A load with the level above the trigger leaves it unchanged.
- R4: A status write with bit 0 = 0 clears the transmit-empty flag only if a status read (`bus_re_i`) returned it as 1 since the last clear. A write with bit 0 = 1, or a clear that was not preceded by such a read, leaves the flag unchanged.
- R5: When the flag is cleared while `tx_level_i <= tx_trig_i`, it reads 0 for one cycle and then sets again.
- R6: If a qualifying clear and a qualifying load fall on the same edge, the clear wins. The R5 recheck then sets the flag again one cycle later.
- R7: `irq_txe_o` is the transmit irq enable AND the transmit-empty flag, registered. It follows either input one cycle later, and it drops one cycle after the enable is cleared.
- R8: `irq_rxf_o` is the receive irq enable AND (receive-full OR `rx_ready_i`), registered. Receive-full is `rx_level_i >= rx_trig_i` and reads as status bit 1. `rx_ready_i` reads as status bit 2.
- R9: Status bits 3 (error), 4 (break) and 5 (overrun) are sticky. They are set by `rx_err_i`, `rx_brk_i` and `rx_ovr_i` respectively, and cleared by a status write with that bit 0. When a set and a clear fall on the same edge, the set wins.
- R10: `irq_err_o` is (receive irq enable OR error irq enable) AND error, registered. `irq_brk_o` is the same enable term AND (break OR overrun), registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Word select: 0 control, 1 status |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe (arms the transmit-empty clear) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the selected word |
| tx_load_i | input | 1 | Byte moved from transmit FIFO to shifter |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| tx_trig_i | input | LVL_W | Transmit trigger threshold |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive trigger threshold |
| rx_ready_i | input | 1 | Receive data-ready condition |
| rx_err_i | input | 1 | Receive error event pulse |
| rx_brk_i | input | 1 | Break detected event pulse |
| rx_ovr_i | input | 1 | Overrun event pulse |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| clk_sel_o | output | 2 | Clock source select |
| irq_txe_o | output | 1 | Transmit-FIFO-empty request |
| irq_rxf_o | output | 1 | Receive-data-full request |
| irq_err_o | output | 1 | Receive-error request |
| irq_brk_o | output | 1 | Break/overrun request |

## Verification
The CPU clear of the transmit-empty flag and a hardware load that would set it can arrive on the same edge. The bench arms the flag with a status read. It then raises `tx_load_i` with a low FIFO level in the same cycle as the write-zero. It expects status bit 0 to read 0 right after that edge and 1 one edge later. In the same way, a sticky overrun pulse is driven together with a clearing write, and the bit must read back as 1.

// File: rtl/sfic_pkg.sv
package sfic_pkg;
  localparam int WORD_W = 16;

  // control word bit positions
  localparam int C_TIE  = 7;
  localparam int C_RIE  = 6;
  localparam int C_TE   = 5;
  localparam int C_RE   = 4;
  localparam int C_REIE = 3;
  localparam logic [WORD_W-1:0] CTL_MASK = 16'h00FB;

  // status word bit positions
  localparam int S_TXE = 0;
  localparam int S_RDF = 1;
  localparam int S_DR  = 2;
  localparam int S_ERR = 3;
  localparam int S_BRK = 4;
  localparam int S_OVR = 5;
  localparam int N_STICKY = 3;

  typedef struct packed {
    logic       tie;
    logic       rie;
    logic       te;
    logic       re;
    logic       reie;
    logic [1:0] cks;
  } ctl_t;
endpackage

// File: rtl/sfic_ctl_reg.sv
module sfic_ctl_reg
  import sfic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output ctl_t              ctl_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (wr_i) ctl_q <= wdata_i & CTL_MASK;
  end

  assign rdata_o    = ctl_q;
  assign ctl_o.tie  = ctl_q[C_TIE];
  assign ctl_o.rie  = ctl_q[C_RIE];
  assign ctl_o.te   = ctl_q[C_TE];
  assign ctl_o.re   = ctl_q[C_RE];
  assign ctl_o.reie = ctl_q[C_REIE];
  assign ctl_o.cks  = ctl_q[1:0];

  // R2: written value appears masked on the next cycle
  a_r2_masked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rdata_o == ($past(wdata_i) & CTL_MASK));
endmodule

// File: rtl/sfic_tx_flag.sv
module sfic_tx_flag #(
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             wbit_i,
  output logic             flag_o
);
  logic flag_q, arm_q, clr_q;
  logic below, clr;

  assign below = level_i <= trig_i;
  assign clr   = wr_i && !wbit_i && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= clr;
      if (clr) begin
        // clear wins over a same-cycle set; recheck follows
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else begin
        flag_q <= flag_q || (load_i && below) || (clr_q && below);
        arm_q  <= arm_q || (rd_i && flag_q);
      end
    end
  end

  assign flag_o = flag_q;

  // R4: flag cannot drop unless armed by a read
  a_r4_no_blind_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !arm_q) |=> flag_q);
  // R5: recheck after a clear with level still low
  a_r5_recheck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q && below && !clr) |=> flag_q);
endmodule

// File: rtl/sfic_rx_flags.sv
module sfic_rx_flags
  import sfic_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STICKY-1:0] ev_i,
  input  logic                wr_i,
  input  logic [N_STICKY-1:0] wbits_i,
  output logic [N_STICKY-1:0] flags_o
);
  for (genvar g = 0; g < N_STICKY; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q <= 1'b0;
      else if (ev_i[g])             q <= 1'b1;
      else if (wr_i && !wbits_i[g]) q <= 1'b0;
    end
    assign flags_o[g] = q;

    // R9: an event is never lost
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[g] |=> q);
  end
endmodule

// File: rtl/sfifo_irq_ctrl.sv
module sfifo_irq_ctrl
  import sfic_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  input  logic              tx_load_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  tx_trig_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  rx_trig_i,
  input  logic              rx_ready_i,
  input  logic              rx_err_i,
  input  logic              rx_brk_i,
  input  logic              rx_ovr_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic [1:0]        clk_sel_o,
  output logic              irq_txe_o,
  output logic              irq_rxf_o,
  output logic              irq_err_o,
  output logic              irq_brk_o
);
  ctl_t              ctl;
  logic [WORD_W-1:0] ctl_rdata, sts_rdata;
  logic              txe, rdf;
  logic [N_STICKY-1:0] sticky;
  logic              err_en;

  sfic_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_we_i && !bus_sel_i),
    .wdata_i (bus_wdata_i),
    .ctl_o   (ctl),
    .rdata_o (ctl_rdata)
  );

  sfic_tx_flag #(.LVL_W(LVL_W)) u_txf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tx_load_i),
    .level_i (tx_level_i),
    .trig_i  (tx_trig_i),
    .rd_i    (bus_re_i && bus_sel_i),
    .wr_i    (bus_we_i && bus_sel_i),
    .wbit_i  (bus_wdata_i[S_TXE]),
    .flag_o  (txe)
  );

  sfic_rx_flags u_rxf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    ({rx_ovr_i, rx_brk_i, rx_err_i}),
    .wr_i    (bus_we_i && bus_sel_i),
    .wbits_i (bus_wdata_i[S_OVR:S_ERR]),
    .flags_o (sticky)
  );

  assign rdf = rx_level_i >= rx_trig_i;

  always_comb begin
    sts_rdata               = '0;
    sts_rdata[S_TXE]        = txe;
    sts_rdata[S_RDF]        = rdf;
    sts_rdata[S_DR]         = rx_ready_i;
    sts_rdata[S_OVR:S_ERR]  = sticky;
  end

  assign bus_rdata_o = bus_sel_i ? sts_rdata : ctl_rdata;
  assign tx_en_o     = ctl.te;
  assign rx_en_o     = ctl.re;
  assign clk_sel_o   = ctl.cks;
  assign err_en      = ctl.rie || ctl.reie;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_txe_o <= 1'b0;
      irq_rxf_o <= 1'b0;
      irq_err_o <= 1'b0;
      irq_brk_o <= 1'b0;
    end else begin
      irq_txe_o <= ctl.tie && txe;
      irq_rxf_o <= ctl.rie && (rdf || rx_ready_i);
      irq_err_o <= err_en && sticky[0];
      irq_brk_o <= err_en && (sticky[1] || sticky[2]);
    end
  end

  // R7: transmit request off one cycle after its enable is low
  a_r7_tie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.tie |=> !irq_txe_o);
  // R8: data-ready with enable raises the receive request
  a_r8_ready_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl.rie && rx_ready_i) |=> irq_rxf_o);
  // R10: no error or break request with both enables low
  a_r10_err_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_en |=> !(irq_err_o || irq_brk_o));
  // R3: qualifying load sets the flag seen on the status port
  a_r3_load_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_i && tx_level_i <= tx_trig_i && !(bus_we_i && bus_sel_i)) |=> txe);
endmodule

// File: tb/sfifo_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sfifo_irq_ctrl_tb_top;
  localparam int LVL_W = 5;

  logic clk = 0, rst_ni = 0;
  logic bus_sel = 0, bus_we = 0, bus_re = 0;
  logic [15:0] wdata = '0, rdata;
  logic tx_load = 0, rx_ready = 0, rx_err = 0, rx_brk = 0, rx_ovr = 0;
  logic [LVL_W-1:0] tx_level = '0, tx_trig = 5'd4, rx_level = '0, rx_trig = 5'd4;
  logic tx_en, rx_en, irq_txe, irq_rxf, irq_err, irq_brk;
  logic [1:0] clk_sel;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sfifo_irq_ctrl #(.LVL_W(LVL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_re_i(bus_re), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tx_load_i(tx_load), .tx_level_i(tx_level), .tx_trig_i(tx_trig),
    .rx_level_i(rx_level), .rx_trig_i(rx_trig), .rx_ready_i(rx_ready),
    .rx_err_i(rx_err), .rx_brk_i(rx_brk), .rx_ovr_i(rx_ovr),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .clk_sel_o(clk_sel),
    .irq_txe_o(irq_txe), .irq_rxf_o(irq_rxf), .irq_err_o(irq_err), .irq_brk_o(irq_brk)
  );

  // {write data, expected readback}
  localparam logic [31:0] VEC [6] = '{
    {16'hFFFF, 16'h00FB}, {16'h00A5, 16'h00A1}, {16'h005A, 16'h005A},
    {16'h0004, 16'h0000}, {16'h1234, 16'h0030}, {16'h0013, 16'h0013}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    bus_sel = sel; wdata = d; bus_we = 1; tick(); bus_we = 0;
  endtask

  task automatic rd(input logic sel);
    bus_sel = sel; bus_re = 1; tick(); bus_re = 0;
  endtask

  function automatic logic [15:0] peek_sts(); return 16'(0); endfunction

  task automatic sts(input string req, input int bitn, input logic exp);
    bus_sel = 1; #1; check(req, 16'(rdata[bitn]), 16'(exp));
  endtask

  task automatic pulse_load();
    tx_load = 1; tick(); tx_load = 0;
  endtask

  task automatic irqs(input string req, input logic [3:0] exp);
    check(req, 16'({irq_txe, irq_rxf, irq_err, irq_brk}), 16'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_ni = 1; @(negedge clk);
    // R1 reset state
    bus_sel = 0; #1; check("R1 ctl", rdata, 16'h0000);
    bus_sel = 1; #1; check("R1 sts", rdata, 16'h0000);
    irqs("R1 irq", 4'b0000);

    // R2 table walk
    foreach (VEC[i]) begin
      wr(0, VEC[i][31:16]);
      bus_sel = 0; #1;
      check("R2 readback", rdata, VEC[i][15:0]);
      check("R2 pins", {12'h0, tx_en, rx_en, clk_sel},
            {12'h0, VEC[i][5], VEC[i][4], VEC[i][1:0]});
    end
    wr(0, 16'h0000);

    // R3 load above trigger: no set; below: set
    tx_level = 5'd8; pulse_load(); sts("R3 above", 0, 1'b0);
    tx_level = 5'd4; pulse_load(); sts("R3 at trig", 0, 1'b1);
    tick(); irqs("R7 tie off", 4'b0000);
    wr(0, 16'h0080); tick(); irqs("R7 tie on", 4'b1000);

    // R4 blind clear ignored; write 1 ignored
    wr(1, 16'h0000); sts("R4 no read", 0, 1'b1);
    rd(1); wr(1, 16'h0001); sts("R4 write one", 0, 1'b1);
    tx_level = 5'd8; wr(1, 16'h0000); sts("R4 cleared", 0, 1'b0);
    tick(); sts("R5 no recheck above", 0, 1'b0); irqs("R7 drop", 4'b0000);

    // R5 recheck with level still low
    tx_level = 5'd2; pulse_load(); rd(1);
    wr(1, 16'h0000); sts("R5 clear", 0, 1'b0);
    tick(); sts("R5 reset", 0, 1'b1);

    // R6 clear and load on the same edge
    rd(1);
    bus_sel = 1; wdata = 16'h0000; bus_we = 1; tx_load = 1; tick();
    bus_we = 0; tx_load = 0;
    sts("R6 clear wins", 0, 1'b0);
    tick(); sts("R6 recheck", 0, 1'b1);

    // R7 drop on enable cleared
    tick(); irqs("R7 high", 4'b1000);
    wr(0, 16'h0000); irqs("R7 lag", 4'b1000);
    tick(); irqs("R7 tie cleared", 4'b0000);

    // R8 receive full / data ready
    wr(0, 16'h0040); tick(); irqs("R8 idle", 4'b0000);
    rx_level = 5'd4; tick(); irqs("R8 full", 4'b0100); sts("R8 rdf bit", 1, 1'b1);
    rx_level = 5'd3; tick(); irqs("R8 below", 4'b0000);
    rx_ready = 1; tick(); irqs("R8 ready", 4'b0100); sts("R8 dr bit", 2, 1'b1);
    wr(0, 16'h0000); tick(); irqs("R8 rie off", 4'b0000);
    rx_ready = 0;

    // R9/R10 error
    rx_err = 1; tick(); rx_err = 0; sts("R9 err set", 3, 1'b1);
    tick(); irqs("R10 err gated", 4'b0000);
    wr(0, 16'h0008); tick(); irqs("R10 reie", 4'b0010);
    wr(0, 16'h0040); tick(); irqs("R10 rie", 4'b0010);
    wr(1, 16'hFFF7); sts("R9 err clear", 3, 1'b0); sts("R4 bit0 one kept", 0, 1'b1);
    tick(); irqs("R10 err drop", 4'b0000);

    // R9/R10 break, overrun
    rx_brk = 1; tick(); rx_brk = 0; sts("R9 brk", 4, 1'b1);
    tick(); irqs("R10 brk", 4'b0001);
    wr(1, 16'hFFEF); sts("R9 brk clear", 4, 1'b0);
    rx_ovr = 1; tick(); rx_ovr = 0; sts("R9 ovr", 5, 1'b1);
    tick(); irqs("R10 ovr", 4'b0001);
    bus_sel = 1; wdata = 16'hFFDF; bus_we = 1; rx_ovr = 1; tick();
    bus_we = 0; rx_ovr = 0;
    sts("R9 set wins", 5, 1'b1);

    // R1 reset mid-run
    rst_ni = 0; #1;
    bus_sel = 0; #1; check("R1 ctl again", rdata, 16'h0000);
    bus_sel = 1; #1; check("R1 sts again", rdata & 16'hFFF9, 16'h0000);
    irqs("R1 irq again", 4'b0000);
    tick(); rst_ni = 1;

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule